// File: doc/BRIEF.md
# Diagonally Interleaved Search-Window Memory

This block holds a search window of previous-frame pixels for a motion estimator. The pixels are spread over NB banks, and each bank can serve one access per clock. A pixel at row `i`, column `j` lives in bank `(i+j) mod NB`, at in-bank word `i*(WIN_W/NB) + floor(j/NB)`. With this diagonal placement, any NB pixels that sit next to each other along a row land in NB different banks. The same holds for NB pixels along a column. Either kind of run is therefore fetched in a single cycle.

A fetch request gives a start coordinate and a direction. The block derives one address per bank and reads all banks together. A barrel rotation, keyed by the start's diagonal `(row+col) mod NB`, puts the returned words back into run order. A second output feeds a consumer that takes half the words per cycle. Each fetched run is split into its even-indexed and odd-indexed words, and the two halves are presented on two successive cycles.

An external frame store fills the window through a single-pixel write port. A write always wins the banks, so a fetch offered in the same cycle is refused and must be held by the requester.

Top module: `swm_window_mem`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_valid` and `half_valid` are low.
- R2: A row fetch (`rd_dir`=0) accepted at start (r,c) raises `rd_valid` for exactly one cycle, one clock after acceptance. In that cycle, element k of `rd_data` (bits k*PIX_W upward) holds pixel (r, c+k).
- R3: A column fetch (`rd_dir`=1) accepted at (r,c) returns pixel (r+k, c) in element k, with the same timing as R2.
- R4: Every start whose run lies fully inside the window is fetched correctly, whatever its diagonal phase (r+c) mod NB is. The requester keeps runs inside the window.
- R5: Fetches accepted on consecutive cycles return their results on consecutive cycles, in order.
- R6: A pixel written with `wr_en` is returned by every later fetch that covers it, and no other pixel changes. While `wr_en` is high, `rd_ready` is low, and a fetch offered then produces no `rd_valid` on the next cycle.
- R7: One cycle after `rd_valid`, `half_valid` is 1 and `half_odd` is 0, with half-element m equal to run word 2m. On the next cycle `half_odd` is 1 and half-element m is word 2m+1. After that, `half_valid` drops unless a new result has arrived.
- R8: A new fetch result arriving while the odd half is still pending replaces it. The half stream restarts at the even half of the newer run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write one pixel this cycle |
| wr_row | input | $clog2(WIN_H) | Write row |
| wr_col | input | $clog2(WIN_W) | Write column |
| wr_pix | input | PIX_W | Write pixel value |
| rd_req | input | 1 | Fetch request |
| rd_row | input | $clog2(WIN_H) | Run start row |
| rd_col | input | $clog2(WIN_W) | Run start column |
| rd_dir | input | 1 | 0 = along a row, 1 = down a column |
| rd_ready | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | Fetch result valid |
| rd_data | output | NB*PIX_W | Run in natural order, element k at bits k*PIX_W |
| half_valid | output | 1 | Half-rate word group valid |
| half_odd | output | 1 | 0 = even-indexed words, 1 = odd-indexed words |
| half_data | output | NB/2*PIX_W | Half-rate words, element m at bits m*PIX_W |

## Verification
Results arrive at fixed delays from acceptance:
- `rd_data` is due one clock after the edge that accepts a fetch.
- The even half is due two clocks after acceptance.
- The odd half is due three clocks after acceptance.

The bench drives inputs and samples outputs only on falling edges, so each check lands exactly that many falling edges after the request. The fetch sweeps cover every start row and column in both directions. A back-to-back run checks the full-width and half-rate streams at the same time, with the half stream lagging by one clock. The write/fetch collision test is followed by a read-back that looks for the new pixel inside a run.

// File: rtl/swm_pkg.sv
package swm_pkg;
   typedef enum logic {
      SWM_ROW = 1'b0,
      SWM_COL = 1'b1
   } swm_dir_e;
endpackage

// File: rtl/swm_addr_gen.sv
// Per-bank address for an NB-long run starting at (row_i, col_i).
// Run word k falls in bank (row+col+k) mod NB, so bank b serves word
// k = (b - phase) mod NB.
module swm_addr_gen
   import swm_pkg::*;
#(
   parameter int NB    = 4,
   parameter int WIN_W = 16,
   parameter int WIN_H = 16,
   localparam int LGN  = $clog2(NB),
   localparam int RW   = $clog2(WIN_H),
   localparam int CW   = $clog2(WIN_W),
   localparam int WPB  = WIN_W / NB,
   localparam int AW   = $clog2(WIN_H * WPB)
) (
   input  logic [RW-1:0]          row_i,
   input  logic [CW-1:0]          col_i,
   input  swm_dir_e               dir_i,
   output logic [LGN-1:0]         phase_o,
   output logic [NB-1:0][AW-1:0]  addr_o
);

   assign phase_o = row_i[LGN-1:0] + col_i[LGN-1:0];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [LGN-1:0] k;
      logic [RW-1:0]  ri;
      logic [CW-1:0]  ci;
      always_comb begin
         k  = LGN'(b) - phase_o;
         ri = (dir_i == SWM_COL) ? row_i + RW'(k) : row_i;
         ci = (dir_i == SWM_ROW) ? col_i + CW'(k) : col_i;
         addr_o[b] = AW'(ri) * AW'(WPB) + AW'(ci >> LGN);
      end
   end

endmodule

// File: rtl/swm_bank.sv
// One single-port bank: a write takes the port, a read is registered.
module swm_bank #(
   parameter int DEPTH = 64,
   parameter int PW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic          re_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [AW-1:0] raddr_i,
   input  logic [PW-1:0] wdata_i,
   output logic [PW-1:0] rdata_o
);

   logic [PW-1:0] mem [DEPTH];
   logic [AW-1:0] port_addr;

   assign port_addr = we_i ? waddr_i : raddr_i;

   always_ff @(posedge clk) begin
      if (we_i)      mem[port_addr] <= wdata_i;
      else if (re_i) rdata_o        <= mem[port_addr];
   end

   AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && re_i) |=> $stable(rdata_o)); // R6

endmodule

// File: rtl/swm_rotate.sv
// Puts bank outputs back into run order: element k comes from bank (phase+k) mod NB.
module swm_rotate #(
   parameter int NB   = 4,
   parameter int PW   = 8,
   localparam int LGN = $clog2(NB)
) (
   input  logic [LGN-1:0]         phase_i,
   input  logic [NB-1:0][PW-1:0]  bank_i,
   output logic [NB-1:0][PW-1:0]  run_o
);

   for (genvar k = 0; k < NB; k++) begin : g_out
      logic [LGN-1:0] src;
      assign src      = phase_i + LGN'(k);
      assign run_o[k] = bank_i[src];
   end

endmodule

// File: rtl/swm_halfbuf.sv
// Even/odd split of one run, presented over two cycles to a half-rate consumer.
module swm_halfbuf #(
   parameter int NB   = 4,
   parameter int PW   = 8,
   localparam int NH  = NB / 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [NB-1:0][PW-1:0]  run_i,
   output logic                   valid_o,
   output logic                   odd_o,
   output logic [NH-1:0][PW-1:0]  data_o
);

   logic [NH-1:0][PW-1:0] even_q, odd_q;

   for (genvar m = 0; m < NH; m++) begin : g_split
      always_ff @(posedge clk) begin
         if (load_i) begin
            even_q[m] <= run_i[2*m];
            odd_q[m]  <= run_i[2*m+1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         odd_o   <= 1'b0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         odd_o   <= 1'b0;
      end else if (valid_o && !odd_o) begin
         odd_o   <= 1'b1;
      end else begin
         valid_o <= 1'b0;
         odd_o   <= 1'b0;
      end
   end

   assign data_o = odd_o ? odd_q : even_q;

   AST_HALF_EVEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (valid_o && !odd_o)); // R7
   AST_HALF_ODD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !odd_o && !load_i) |=> (valid_o && odd_o)); // R7
   AST_HALF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && odd_o && !load_i) |=> !valid_o); // R7
   AST_HALF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !odd_o && load_i) |=> !odd_o); // R8

endmodule

// File: rtl/swm_window_mem.sv
module swm_window_mem
   import swm_pkg::*;
#(
   parameter int NB    = 4,
   parameter int WIN_W = 16,
   parameter int WIN_H = 16,
   parameter int PIX_W = 8,
   localparam int LGN  = $clog2(NB),
   localparam int RW   = $clog2(WIN_H),
   localparam int CW   = $clog2(WIN_W),
   localparam int WPB  = WIN_W / NB,
   localparam int DEPTH = WIN_H * WPB,
   localparam int AW   = $clog2(DEPTH),
   localparam int NH   = NB / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [RW-1:0]        wr_row,
   input  logic [CW-1:0]        wr_col,
   input  logic [PIX_W-1:0]     wr_pix,
   input  logic                 rd_req,
   input  logic [RW-1:0]        rd_row,
   input  logic [CW-1:0]        rd_col,
   input  logic                 rd_dir,
   output logic                 rd_ready,
   output logic                 rd_valid,
   output logic [NB*PIX_W-1:0]  rd_data,
   output logic                 half_valid,
   output logic                 half_odd,
   output logic [NH*PIX_W-1:0]  half_data
);

   // elaboration-time parameter checks
   if (NB < 2 || (NB & (NB - 1)) != 0) begin : g_bad_nb
      $error("NB must be a power of two and at least 2");
   end
   if (WIN_W % NB != 0) begin : g_bad_w
      $error("WIN_W must be a multiple of NB");
   end
   if (WIN_H < NB || WIN_W < NB) begin : g_bad_h
      $error("window must be at least NB pixels on each side");
   end

   logic                       rd_fire;
   logic [LGN-1:0]             wr_bank;
   logic [AW-1:0]              wr_addr;
   logic [LGN-1:0]             rd_phase, phase_q;
   logic [NB-1:0][AW-1:0]      rd_addr;
   logic [NB-1:0][PIX_W-1:0]   bank_q, run;
   logic [NH-1:0][PIX_W-1:0]   half_w;
   swm_dir_e                   dir;

   assign dir      = swm_dir_e'(rd_dir);
   assign rd_ready = !wr_en;          // every fetch needs all banks
   assign rd_fire  = rd_req && rd_ready;
   assign wr_bank  = wr_row[LGN-1:0] + wr_col[LGN-1:0];
   assign wr_addr  = AW'(wr_row) * AW'(WPB) + AW'(wr_col >> LGN);

   swm_addr_gen #(.NB(NB), .WIN_W(WIN_W), .WIN_H(WIN_H)) addr_i (
      .row_i   (rd_row),
      .col_i   (rd_col),
      .dir_i   (dir),
      .phase_o (rd_phase),
      .addr_o  (rd_addr)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      swm_bank #(.DEPTH(DEPTH), .PW(PIX_W)) bank_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (wr_en && (wr_bank == LGN'(b))),
         .re_i    (rd_req),
         .waddr_i (wr_addr),
         .raddr_i (rd_addr[b]),
         .wdata_i (wr_pix),
         .rdata_o (bank_q[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         phase_q  <= '0;
      end else begin
         rd_valid <= rd_fire;
         if (rd_fire) phase_q <= rd_phase;
      end
   end

   swm_rotate #(.NB(NB), .PW(PIX_W)) rot_i (
      .phase_i (phase_q),
      .bank_i  (bank_q),
      .run_o   (run)
   );

   assign rd_data = run;

   swm_halfbuf #(.NB(NB), .PW(PIX_W)) half_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (rd_valid),
      .run_i   (run),
      .valid_o (half_valid),
      .odd_o   (half_odd),
      .data_o  (half_w)
   );

   assign half_data = half_w;

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> rd_valid); // R2
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> !rd_valid); // R5
   AST_STALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && wr_en) |=> !rd_valid); // R6
   AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> ((dir == SWM_ROW) ? ({1'b0, rd_col} + (CW+1)'(NB) <= (CW+1)'(WIN_W))
                                   : ({1'b0, rd_row} + (RW+1)'(NB) <= (RW+1)'(WIN_H)))); // R4

endmodule

// File: tb/swm_window_mem_tb.sv
module swm_window_mem_tb_top;
   localparam int NB = 4, WIN_W = 16, WIN_H = 16, PIX_W = 8;
   localparam int RW = $clog2(WIN_H), CW = $clog2(WIN_W), NH = NB / 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, rd_req = 1'b0, rd_dir = 1'b0;
   logic [RW-1:0] wr_row = '0, rd_row = '0;
   logic [CW-1:0] wr_col = '0, rd_col = '0;
   logic [PIX_W-1:0] wr_pix = '0;
   logic rd_ready, rd_valid, half_valid, half_odd;
   logic [NB*PIX_W-1:0] rd_data;
   logic [NH*PIX_W-1:0] half_data;

   logic [PIX_W-1:0] ref_mem [WIN_H][WIN_W];
   int n_vec = 0, n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   swm_window_mem #(.NB(NB), .WIN_W(WIN_W), .WIN_H(WIN_H), .PIX_W(PIX_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
      .wr_pix(wr_pix), .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
      .rd_dir(rd_dir), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .half_valid(half_valid), .half_odd(half_odd), .half_data(half_data));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [PIX_W-1:0] word_of(input int r, input int c, input int d, input int k);
      return d ? ref_mem[r+k][c] : ref_mem[r][c+k];
   endfunction

   function automatic logic [NB*PIX_W-1:0] run_of(input int r, input int c, input int d);
      logic [NB*PIX_W-1:0] v;
      for (int k = 0; k < NB; k++) v[k*PIX_W +: PIX_W] = word_of(r, c, d, k);
      return v;
   endfunction

   function automatic logic [NH*PIX_W-1:0] half_of(input logic [NB*PIX_W-1:0] v, input int odd);
      logic [NH*PIX_W-1:0] h;
      for (int m = 0; m < NH; m++) h[m*PIX_W +: PIX_W] = v[(2*m+odd)*PIX_W +: PIX_W];
      return h;
   endfunction

   task automatic put_pix(input int r, input int c, input logic [PIX_W-1:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_row = RW'(r); wr_col = CW'(c); wr_pix = v;
      ref_mem[r][c] = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // one isolated fetch with full and half-rate checks
   task automatic fetch(input int r, input int c, input int d, input string req);
      logic [NB*PIX_W-1:0] e;
      e = run_of(r, c, d);
      @(negedge clk);
      rd_req = 1'b1; rd_row = RW'(r); rd_col = CW'(c); rd_dir = d[0];
      @(negedge clk);
      rd_req = 1'b0;
      chk(req, {63'd0, rd_valid}, 64'd1);
      chk(req, 64'(rd_data), 64'(e));
      @(negedge clk);
      chk("R7 even half", {62'd0, half_valid, half_odd}, 64'd2);
      chk("R7 even data", 64'(half_data), 64'(half_of(e, 0)));
      chk("R2 single pulse", {63'd0, rd_valid}, 64'd0);
      @(negedge clk);
      chk("R7 odd half", {62'd0, half_valid, half_odd}, 64'd3);
      chk("R7 odd data", 64'(half_data), 64'(half_of(e, 1)));
      @(negedge clk);
      chk("R7 half ends", {63'd0, half_valid}, 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset rd_valid", {63'd0, rd_valid}, 64'd0);
      chk("R1 reset half_valid", {63'd0, half_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {62'd0, rd_valid, half_valid}, 64'd0);

      // fill the window: value unique per pixel
      for (int r = 0; r < WIN_H; r++)
         for (int c = 0; c < WIN_W; c++)
            put_pix(r, c, PIX_W'((r * WIN_W + c) * 7 + 3));

      // R2/R4: every row start, every phase
      for (int r = 0; r < WIN_H; r++)
         for (int c = 0; c + NB <= WIN_W; c++)
            fetch(r, c, 0, "R2 R4 row fetch");
      // R3/R4: every column start
      for (int r = 0; r + NB <= WIN_H; r++)
         for (int c = 0; c < WIN_W; c++)
            fetch(r, c, 1, "R3 R4 column fetch");

      // R5/R8: back-to-back fetches, alternating direction
      begin
         localparam int L = 12;
         logic [NB*PIX_W-1:0] exp_q [L];
         for (int n = 0; n < L; n++) exp_q[n] = run_of(n, n % 5, n % 2);
         for (int t = 0; t <= L + 2; t++) begin
            @(negedge clk);
            if (t >= 1 && t <= L) begin
               chk("R5 streaming valid", {63'd0, rd_valid}, 64'd1);
               chk("R5 streaming data", 64'(rd_data), 64'(exp_q[t-1]));
            end
            if (t >= 2 && t <= L + 1) begin
               chk("R8 restart even", {62'd0, half_valid, half_odd}, 64'd2);
               chk("R8 restart data", 64'(half_data), 64'(half_of(exp_q[t-2], 0)));
            end
            if (t == L + 2) begin
               chk("R8 final odd", {62'd0, half_valid, half_odd}, 64'd3);
               chk("R8 final odd data", 64'(half_data), 64'(half_of(exp_q[L-1], 1)));
            end
            if (t < L) begin
               rd_req = 1'b1; rd_row = RW'(t); rd_col = CW'(t % 5); rd_dir = 1'(t % 2);
            end else rd_req = 1'b0;
         end
      end

      // R6: write and fetch in the same cycle
      repeat (3) @(negedge clk);
      wr_en = 1'b1; wr_row = 4'd3; wr_col = 4'd7; wr_pix = 8'hA5; ref_mem[3][7] = 8'hA5;
      rd_req = 1'b1; rd_row = 4'd3; rd_col = 4'd4; rd_dir = 1'b0;
      #1 chk("R6 ready low on write", {63'd0, rd_ready}, 64'd0);
      @(negedge clk);
      wr_en = 1'b0; rd_req = 1'b0;
      chk("R6 refused fetch", {63'd0, rd_valid}, 64'd0);
      fetch(3, 4, 0, "R6 written pixel in row");
      fetch(0, 7, 1, "R6 written pixel in column");
      fetch(3, 8, 0, "R6 neighbour unchanged");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule